// File: doc/BRIEF.md
# Unaligned Word Merge Unit

This block is the byte-merge datapath behind the four partial-word memory instructions of a 32-bit core: load-left, load-right, store-left and store-right. Each cycle it may accept one operation, given as a 6-bit major opcode, the effective byte address, the present value of the target register and the aligned memory word already fetched from the word that contains the address. It produces, one clock later, either the merged register value or the merged word to write back to memory, together with the aligned word address and a byte-enable pattern.

A load keeps the register bytes that lie outside the addressed range and fills the rest from the shifted memory word. A store is read-modify-write: the selected register bytes are shifted into position and replace only their lanes of the fetched word, which then goes back to the same aligned address. The side of the word that is merged, and the shift direction, depend on the byte order, which is an elaboration parameter. A fault reported with the operation drops every write strobe. Because the block works on values handed to it, a base register that is also the target cannot disturb the address once the operation is presented.

Top module: `unaligned_word_merge`

## Requirements
- R1: While reset is asserted and on the first sampled cycle after it, out_valid, out_reg_wr and out_mem_wr are 0 and out_byte_en is 0.
- R2: An operation presented with in_valid high appears with out_valid high exactly one clock later; a cycle without in_valid yields out_valid low one clock later.
- R3: Big-endian (byte offset o = in_addr[1:0], lane i is bits 8i+7..8i, lane 3 holds offset 0), opcode 0x22 (load-left): lanes o..3 of out_data take the memory word shifted left by 8*o bits; lanes below o keep in_reg.
- R4: Big-endian, opcode 0x26 (load-right): lanes 0..o take the memory word shifted right by 8*(3-o) bits; lanes above o keep in_reg.
- R5: Little-endian (lane 0 holds offset 0): load-left fills lanes 3-o..3 with the memory word shifted left by 8*(3-o); load-right fills lanes 0..3-o with the memory word shifted right by 8*o; all other lanes keep in_reg.
- R6: Stores (0x2a store-left, 0x2e store-right) keep in_mem in unselected lanes. Big-endian: store-left puts in_reg shifted right by 8*o in lanes 0..3-o, store-right puts in_reg shifted left by 8*(3-o) in lanes 3-o..3. Little-endian: store-left puts in_reg shifted right by 8*(3-o) in lanes 0..o, store-right puts in_reg shifted left by 8*o in lanes o..3.
- R7: For a store, out_byte_en bit i is 1 exactly for the lanes that R6 replaces; for every other result out_byte_en is 0.
- R8: out_mem_addr equals in_addr with its two low bits cleared.
- R9: An operation with in_fault high gives out_reg_wr = 0, out_mem_wr = 0 and out_byte_en = 0, while out_data still shows the merged value.
- R10: Any opcode other than the four above gives out_valid high with no write strobe and out_data = 0.
- R11: Big-endian load-left at offset 0 and load-right at offset 3 return the memory word unchanged in all four lanes.
- R12: A valid, fault-free load raises out_reg_wr only; a valid, fault-free store raises out_mem_wr only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation presented this cycle |
| in_opcode | input | 6 | Major opcode selecting the operation |
| in_addr | input | 32 | Effective byte address |
| in_reg | input | 32 | Current target register value |
| in_mem | input | 32 | Aligned memory word read for this operation |
| in_fault | input | 1 | Fault on the access; cancels all updates |
| out_valid | output | 1 | Result present |
| out_reg_wr | output | 1 | Write out_data to the target register |
| out_mem_wr | output | 1 | Write out_data to memory at out_mem_addr |
| out_data | output | 32 | Merged register value or merged memory word |
| out_mem_addr | output | 32 | Word-aligned address of the access |
| out_byte_en | output | 4 | Lanes actually replaced by a store |

## Verification
The assertions assume that in_opcode, in_addr, in_reg, in_mem and in_fault are meaningful only while in_valid is high, and that reset is held for at least one clock before the first operation. They relate each result to the inputs of the previous cycle only, so they take for granted that nothing stalls the single register stage. The stimulus changes inputs only half a period before the capturing edge, drops in_valid between bursts to exercise idle cycles, and sweeps every opcode and offset with fault both high and low plus an unknown opcode, on a big-endian and a little-endian instance fed in parallel.

// File: rtl/uwm_pkg.sv
package uwm_pkg;

   // Kind of partial-word operation after decode.
   typedef enum logic [1:0] {
      KIND_LOAD_HI  = 2'd0,
      KIND_LOAD_LO  = 2'd1,
      KIND_STORE_HI = 2'd2,
      KIND_STORE_LO = 2'd3
   } uwm_kind_e;

   function automatic logic kind_is_load(uwm_kind_e k);
      return (k == KIND_LOAD_HI) || (k == KIND_LOAD_LO);
   endfunction

endpackage

// File: rtl/uwm_decode.sv
module uwm_decode
   import uwm_pkg::*;
#(
   parameter int unsigned        OPC_W      = 6,
   parameter logic [OPC_W-1:0]   OPC_LD_HI  = 6'h22,
   parameter logic [OPC_W-1:0]   OPC_LD_LO  = 6'h26,
   parameter logic [OPC_W-1:0]   OPC_ST_HI  = 6'h2a,
   parameter logic [OPC_W-1:0]   OPC_ST_LO  = 6'h2e
) (
   input  logic [OPC_W-1:0] opcode,
   output logic             legal,
   output uwm_kind_e        kind
);

   generate
      if ((OPC_LD_HI == OPC_LD_LO) || (OPC_LD_HI == OPC_ST_HI) ||
          (OPC_LD_HI == OPC_ST_LO) || (OPC_LD_LO == OPC_ST_HI) ||
          (OPC_LD_LO == OPC_ST_LO) || (OPC_ST_HI == OPC_ST_LO)) begin : g_bad_opc
         $error("uwm_decode: opcode parameters must be distinct");
      end
   endgenerate

   always_comb begin
      legal = 1'b1;
      kind  = KIND_LOAD_HI;
      if (opcode == OPC_LD_HI) begin
         kind = KIND_LOAD_HI;
      end else if (opcode == OPC_LD_LO) begin
         kind = KIND_LOAD_LO;
      end else if (opcode == OPC_ST_HI) begin
         kind = KIND_STORE_HI;
      end else if (opcode == OPC_ST_LO) begin
         kind = KIND_STORE_LO;
      end else begin
         legal = 1'b0;
      end
   end

endmodule

// File: rtl/uwm_lane_ctrl.sv
module uwm_lane_ctrl
   import uwm_pkg::*;
#(
   parameter int unsigned LANES      = 4,
   parameter bit          BIG_ENDIAN = 1'b1,
   localparam int unsigned OFS_W     = $clog2(LANES)
) (
   input  uwm_kind_e          kind,
   input  logic [OFS_W-1:0]   ofs,
   output logic               shift_up,
   output logic [OFS_W-1:0]   shift_bytes,
   output logic [LANES-1:0]   lane_mask
);

   localparam logic [OFS_W-1:0] TOP_LANE = OFS_W'(LANES - 1);

   // Distance of the addressed byte from the most significant end of
   // the word, in bytes.  Byte order picks how the offset maps.
   logic [OFS_W-1:0] near_dist;

   generate
      if (BIG_ENDIAN) begin : g_big
         assign near_dist = ofs;
      end else begin : g_little
         assign near_dist = TOP_LANE - ofs;
      end
   endgenerate

   always_comb begin
      unique case (kind)
         KIND_LOAD_HI: begin
            shift_up    = 1'b1;
            shift_bytes = near_dist;
         end
         KIND_LOAD_LO: begin
            shift_up    = 1'b0;
            shift_bytes = TOP_LANE - near_dist;
         end
         KIND_STORE_HI: begin
            shift_up    = 1'b0;
            shift_bytes = near_dist;
         end
         default: begin
            shift_up    = 1'b1;
            shift_bytes = TOP_LANE - near_dist;
         end
      endcase
   end

   // A lane is replaced exactly when the shifted source covers it.
   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         assign lane_mask[ln] = shift_up ? (OFS_W'(ln) >= shift_bytes)
                                         : (OFS_W'(ln) <= (TOP_LANE - shift_bytes));
      end
   endgenerate

endmodule

// File: rtl/uwm_byte_merge.sv
module uwm_byte_merge #(
   parameter int unsigned LANES   = 4,
   localparam int unsigned OFS_W  = $clog2(LANES),
   localparam int unsigned DATA_W = 8 * LANES
) (
   input  logic [DATA_W-1:0] src_word,
   input  logic [DATA_W-1:0] dst_word,
   input  logic              shift_up,
   input  logic [OFS_W-1:0]  shift_bytes,
   input  logic [LANES-1:0]  lane_mask,
   output logic [DATA_W-1:0] merged
);

   logic [OFS_W+2:0]  bit_shift;
   logic [DATA_W-1:0] aligned_src;

   assign bit_shift   = {shift_bytes, 3'b000};
   assign aligned_src = shift_up ? (src_word << bit_shift) : (src_word >> bit_shift);

   generate
      for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
         assign merged[8*ln +: 8] = lane_mask[ln] ? aligned_src[8*ln +: 8]
                                                  : dst_word[8*ln +: 8];
      end
   endgenerate

endmodule

// File: rtl/uwm_out_stage.sv
module uwm_out_stage #(
   parameter int unsigned LANES   = 4,
   parameter int unsigned ADDR_W  = 32,
   localparam int unsigned DATA_W = 8 * LANES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nxt_valid,
   input  logic              nxt_reg_wr,
   input  logic              nxt_mem_wr,
   input  logic [DATA_W-1:0] nxt_data,
   input  logic [ADDR_W-1:0] nxt_addr,
   input  logic [LANES-1:0]  nxt_be,
   output logic              q_valid,
   output logic              q_reg_wr,
   output logic              q_mem_wr,
   output logic [DATA_W-1:0] q_data,
   output logic [ADDR_W-1:0] q_addr,
   output logic [LANES-1:0]  q_be
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         q_valid  <= 1'b0;
         q_reg_wr <= 1'b0;
         q_mem_wr <= 1'b0;
         q_data   <= '0;
         q_addr   <= '0;
         q_be     <= '0;
      end else begin
         q_valid  <= nxt_valid;
         q_reg_wr <= nxt_reg_wr;
         q_mem_wr <= nxt_mem_wr;
         q_data   <= nxt_data;
         q_addr   <= nxt_addr;
         q_be     <= nxt_be;
      end
   end

   p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      nxt_valid |=> q_valid);
   p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !nxt_valid |=> !q_valid);
   p_strobe_needs_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (q_reg_wr || q_mem_wr) |-> q_valid);

endmodule

// File: rtl/unaligned_word_merge.sv
module unaligned_word_merge
   import uwm_pkg::*;
#(
   parameter int unsigned        LANES      = 4,
   parameter int unsigned        ADDR_W     = 32,
   parameter int unsigned        OPC_W      = 6,
   parameter bit                 BIG_ENDIAN = 1'b1,
   parameter logic [OPC_W-1:0]   OPC_LD_HI  = 6'h22,
   parameter logic [OPC_W-1:0]   OPC_LD_LO  = 6'h26,
   parameter logic [OPC_W-1:0]   OPC_ST_HI  = 6'h2a,
   parameter logic [OPC_W-1:0]   OPC_ST_LO  = 6'h2e
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [OPC_W-1:0]     in_opcode,
   input  logic [ADDR_W-1:0]    in_addr,
   input  logic [8*LANES-1:0]   in_reg,
   input  logic [8*LANES-1:0]   in_mem,
   input  logic                 in_fault,
   output logic                 out_valid,
   output logic                 out_reg_wr,
   output logic                 out_mem_wr,
   output logic [8*LANES-1:0]   out_data,
   output logic [ADDR_W-1:0]    out_mem_addr,
   output logic [LANES-1:0]     out_byte_en
);

   localparam int unsigned DATA_W = 8 * LANES;
   localparam int unsigned OFS_W  = $clog2(LANES);

   generate
      if ((LANES < 2) || ((1 << OFS_W) != LANES)) begin : g_bad_lanes
         $error("unaligned_word_merge: LANES must be a power of two, at least 2");
      end
      if (ADDR_W <= OFS_W) begin : g_bad_addr
         $error("unaligned_word_merge: ADDR_W too small for LANES");
      end
   endgenerate

   // ---------------- decode ----------------
   logic      op_legal;
   uwm_kind_e op_kind;

   uwm_decode #(
      .OPC_W    (OPC_W),
      .OPC_LD_HI(OPC_LD_HI),
      .OPC_LD_LO(OPC_LD_LO),
      .OPC_ST_HI(OPC_ST_HI),
      .OPC_ST_LO(OPC_ST_LO)
   ) u_decode (
      .opcode(in_opcode),
      .legal (op_legal),
      .kind  (op_kind)
   );

   // ---------------- lane selection ----------------
   logic [OFS_W-1:0] byte_ofs;
   logic             shift_up;
   logic [OFS_W-1:0] shift_bytes;
   logic [LANES-1:0] lane_mask;

   assign byte_ofs = in_addr[OFS_W-1:0];

   uwm_lane_ctrl #(
      .LANES     (LANES),
      .BIG_ENDIAN(BIG_ENDIAN)
   ) u_lane_ctrl (
      .kind       (op_kind),
      .ofs        (byte_ofs),
      .shift_up   (shift_up),
      .shift_bytes(shift_bytes),
      .lane_mask  (lane_mask)
   );

   // ---------------- merge ----------------
   logic              is_load;
   logic [DATA_W-1:0] src_word;
   logic [DATA_W-1:0] dst_word;
   logic [DATA_W-1:0] merged;

   assign is_load  = kind_is_load(op_kind);
   assign src_word = is_load ? in_mem : in_reg;
   assign dst_word = is_load ? in_reg : in_mem;

   uwm_byte_merge #(
      .LANES(LANES)
   ) u_merge (
      .src_word   (src_word),
      .dst_word   (dst_word),
      .shift_up   (shift_up),
      .shift_bytes(shift_bytes),
      .lane_mask  (lane_mask),
      .merged     (merged)
   );

   // ---------------- write control ----------------
   logic              commit;
   logic              nxt_reg_wr;
   logic              nxt_mem_wr;
   logic [LANES-1:0]  nxt_be;
   logic [DATA_W-1:0] nxt_data;
   logic [ADDR_W-1:0] nxt_addr;

   assign commit     = in_valid && op_legal && !in_fault;
   assign nxt_reg_wr = commit && is_load;
   assign nxt_mem_wr = commit && !is_load;
   assign nxt_be     = nxt_mem_wr ? lane_mask : '0;
   assign nxt_data   = op_legal ? merged : '0;
   assign nxt_addr   = {in_addr[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};

   uwm_out_stage #(
      .LANES (LANES),
      .ADDR_W(ADDR_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .nxt_valid (in_valid),
      .nxt_reg_wr(nxt_reg_wr),
      .nxt_mem_wr(nxt_mem_wr),
      .nxt_data  (nxt_data),
      .nxt_addr  (nxt_addr),
      .nxt_be    (nxt_be),
      .q_valid   (out_valid),
      .q_reg_wr  (out_reg_wr),
      .q_mem_wr  (out_mem_wr),
      .q_data    (out_data),
      .q_addr    (out_mem_addr),
      .q_be      (out_byte_en)
   );

   // ---------------- assertions ----------------
   p_fault_drops_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_fault) |=> (!out_reg_wr && !out_mem_wr && (out_byte_en == '0)));

   p_unknown_opc_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (in_opcode != OPC_LD_HI) && (in_opcode != OPC_LD_LO) &&
       (in_opcode != OPC_ST_HI) && (in_opcode != OPC_ST_LO))
      |=> (!out_reg_wr && !out_mem_wr && (out_data == '0)));

   p_load_no_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !out_mem_wr |-> (out_byte_en == '0));

   p_store_has_be_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_mem_wr |-> (out_byte_en != '0));

   p_one_target_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_reg_wr && out_mem_wr));

   p_word_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (out_mem_addr[ADDR_W-1:OFS_W] == $past(in_addr[ADDR_W-1:OFS_W]))
                   && (out_mem_addr[OFS_W-1:0] == '0));

   p_full_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && BIG_ENDIAN &&
       (((in_opcode == OPC_LD_HI) && (in_addr[OFS_W-1:0] == '0)) ||
        ((in_opcode == OPC_LD_LO) && (in_addr[OFS_W-1:0] == OFS_W'(LANES - 1)))))
      |=> (out_data == $past(in_mem)));

endmodule

// File: tb/unaligned_word_merge_tb_top.sv
`timescale 1ns/1ps
module unaligned_word_merge_tb_top;

   localparam time CLK_PER = 20ns;

   typedef struct {
      int          stamp;
      logic        reg_wr;
      logic        mem_wr;
      logic [31:0] data;
      logic [31:0] addr;
      logic [3:0]  be;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [5:0]  in_opcode = '0;
   logic [31:0] in_addr = '0;
   logic [31:0] in_reg = '0;
   logic [31:0] in_mem = '0;
   logic        in_fault = 1'b0;

   logic        b_valid, b_rw, b_mw;
   logic [31:0] b_data, b_addr;
   logic [3:0]  b_be;
   logic        l_valid, l_rw, l_mw;
   logic [31:0] l_data, l_addr;
   logic [3:0]  l_be;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   bit done = 0;
   exp_t q_big[$];
   exp_t q_lit[$];

   always #(CLK_PER/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   unaligned_word_merge #(.BIG_ENDIAN(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_addr(in_addr), .in_reg(in_reg), .in_mem(in_mem), .in_fault(in_fault),
      .out_valid(b_valid), .out_reg_wr(b_rw), .out_mem_wr(b_mw), .out_data(b_data),
      .out_mem_addr(b_addr), .out_byte_en(b_be));

   unaligned_word_merge #(.BIG_ENDIAN(1'b0)) dut_le_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_opcode(in_opcode),
      .in_addr(in_addr), .in_reg(in_reg), .in_mem(in_mem), .in_fault(in_fault),
      .out_valid(l_valid), .out_reg_wr(l_rw), .out_mem_wr(l_mw), .out_data(l_data),
      .out_mem_addr(l_addr), .out_byte_en(l_be));

   // Expected result built directly from the lane ranges in the requirements.
   function automatic exp_t model(bit big, logic [5:0] opc, logic [31:0] a,
                                  logic [31:0] r, logic [31:0] m, bit f, string tag);
      exp_t e;
      int o = int'(a[1:0]);
      int lo = 0, hi = 3;
      logic [31:0] sh = '0;
      logic [31:0] base = '0;
      bit load = 0, known = 1;
      e.stamp = cyc;
      e.tag = tag;
      e.addr = {a[31:2], 2'b00};
      if (big) begin
         case (opc)
            6'h22: begin load = 1; sh = m << (8*o);     lo = o;     hi = 3; end   // R3
            6'h26: begin load = 1; sh = m >> (8*(3-o)); lo = 0;     hi = o; end   // R4
            6'h2a: begin           sh = r >> (8*o);     lo = 0;     hi = 3-o; end // R6
            6'h2e: begin           sh = r << (8*(3-o)); lo = 3-o;   hi = 3; end   // R6
            default: known = 0;                                                   // R10
         endcase
      end else begin
         case (opc)
            6'h22: begin load = 1; sh = m << (8*(3-o)); lo = 3-o;   hi = 3; end   // R5
            6'h26: begin load = 1; sh = m >> (8*o);     lo = 0;     hi = 3-o; end // R5
            6'h2a: begin           sh = r >> (8*(3-o)); lo = 0;     hi = o; end   // R6
            6'h2e: begin           sh = r << (8*o);     lo = o;     hi = 3; end   // R6
            default: known = 0;
         endcase
      end
      base = load ? r : m;
      e.be = '0;
      e.data = '0;
      if (known) begin
         for (int ln = 0; ln < 4; ln++) begin
            if (ln >= lo && ln <= hi) begin
               e.data[8*ln +: 8] = sh[8*ln +: 8];
               e.be[ln] = 1'b1;
            end else begin
               e.data[8*ln +: 8] = base[8*ln +: 8];
            end
         end
      end
      e.reg_wr = known && load && !f;                 // R12, R9
      e.mem_wr = known && !load && !f;
      if (!e.mem_wr) e.be = '0;                       // R7
      return e;
   endfunction

   task automatic drive(logic [5:0] opc, logic [31:0] a, logic [31:0] r,
                        logic [31:0] m, bit f, string tag);
      @(negedge clk);
      in_valid  = 1'b1;
      in_opcode = opc;
      in_addr   = a;
      in_reg    = r;
      in_mem    = m;
      in_fault  = f;
      q_big.push_back(model(1'b1, opc, a, r, m, f, {tag, " big"}));
      q_lit.push_back(model(1'b0, opc, a, r, m, f, {tag, " little"}));
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid  = 1'b0;
         in_opcode = $urandom();
         in_addr   = $urandom();
         in_fault  = $urandom();
      end
   endtask

   task automatic compare(exp_t e, logic rw, logic mw, logic [31:0] d,
                          logic [31:0] ad, logic [3:0] be);
      checks++;
      if (rw !== e.reg_wr || mw !== e.mem_wr || d !== e.data ||
          ad !== e.addr || be !== e.be) begin   // R8 checked through addr
         errors++;
         $display("FAIL %s: got rw=%0b mw=%0b data=%08h addr=%08h be=%04b, expected rw=%0b mw=%0b data=%08h addr=%08h be=%04b",
                  e.tag, rw, mw, d, ad, be, e.reg_wr, e.mem_wr, e.data, e.addr, e.be);
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && !done) begin
         if (b_valid) begin
            if (q_big.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2: big-endian out_valid=1 with nothing pending, expected 0");
            end else compare(q_big.pop_front(), b_rw, b_mw, b_data, b_addr, b_be);
         end else if (q_big.size() > 0 && q_big[0].stamp + 1 == cyc) begin
            checks++; errors++;
            $display("FAIL R2: big-endian out_valid=0 for %s, expected 1", q_big[0].tag);
            void'(q_big.pop_front());
         end
         if (l_valid) begin
            if (q_lit.size() == 0) begin
               checks++; errors++;
               $display("FAIL R2: little-endian out_valid=1 with nothing pending, expected 0");
            end else compare(q_lit.pop_front(), l_rw, l_mw, l_data, l_addr, l_be);
         end else if (q_lit.size() > 0 && q_lit[0].stamp + 1 == cyc) begin
            checks++; errors++;
            $display("FAIL R2: little-endian out_valid=0 for %s, expected 1", q_lit[0].tag);
            void'(q_lit.pop_front());
         end
      end
   end

   // Watchdog
   initial begin
      #(CLK_PER * 200000);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [5:0] ops [4];
      ops[0] = 6'h22; ops[1] = 6'h26; ops[2] = 6'h2a; ops[3] = 6'h2e;

      // R1: reset state
      repeat (3) @(negedge clk);
      checks++;
      if (b_valid !== 0 || b_rw !== 0 || b_mw !== 0 || b_be !== 0 ||
          l_valid !== 0 || l_rw !== 0 || l_mw !== 0 || l_be !== 0) begin
         errors++;
         $display("FAIL R1: in reset valid=%0b/%0b rw=%0b/%0b mw=%0b/%0b be=%04b/%04b, expected all 0",
                  b_valid, l_valid, b_rw, l_rw, b_mw, l_mw, b_be, l_be);
      end
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (b_valid !== 0 || l_valid !== 0 || b_be !== 0 || l_be !== 0) begin
         errors++;
         $display("FAIL R1: after reset valid=%0b/%0b be=%04b/%04b, expected 0",
                  b_valid, l_valid, b_be, l_be);
      end

      // R11: full-word big-endian loads
      drive(6'h22, 32'h0000_1000, 32'hAAAA_AAAA, 32'h1122_3344, 1'b0, "R11 load-left ofs0");
      drive(6'h26, 32'h0000_1003, 32'hAAAA_AAAA, 32'h5566_7788, 1'b0, "R11 load-right ofs3");
      idle(2);

      // R3 R4 R5 R6 R7 R12: every op, every offset, two data patterns, back to back
      for (int op = 0; op < 4; op++) begin
         for (int o = 0; o < 4; o++) begin
            drive(ops[op], 32'h8000_0040 + o, 32'h0102_0304, 32'hA1B2_C3D4, 1'b0,
                  $sformatf("R3 R4 R5 R6 R7 R12 op=%02h ofs=%0d pat0", ops[op], o));
            drive(ops[op], 32'h1234_5670 + o, 32'hDEAD_BEEF, 32'h0F1E_2D3C, 1'b0,
                  $sformatf("R3 R4 R5 R6 R7 R12 op=%02h ofs=%0d pat1", ops[op], o));
         end
         idle(1);
      end

      // R9: faults suppress strobes
      for (int op = 0; op < 4; op++) begin
         drive(ops[op], 32'h0000_2001 + op, 32'hCAFE_F00D, 32'h7654_3210, 1'b1,
               $sformatf("R9 fault op=%02h", ops[op]));
      end
      idle(2);

      // R10: unknown opcodes
      drive(6'h23, 32'h0000_3002, 32'h1111_1111, 32'h2222_2222, 1'b0, "R10 opc 23");
      drive(6'h00, 32'h0000_3001, 32'h3333_3333, 32'h4444_4444, 1'b0, "R10 opc 00");
      idle(1);

      // R8 R2: random mix with gaps
      for (int i = 0; i < 60; i++) begin
         drive(ops[$urandom_range(3)], $urandom(), $urandom(), $urandom(),
               ($urandom_range(7) == 0), "R8 R2 random");
         if ($urandom_range(2) == 0) idle(1);
      end
      idle(4);

      // R2: nothing left outstanding
      checks++;
      if (q_big.size() != 0 || q_lit.size() != 0) begin
         errors++;
         $display("FAIL R2: pending results big=%0d little=%0d, expected 0 0",
                  q_big.size(), q_lit.size());
      end

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule